// File: doc/BRIEF.md
# DDR2 Command and Bank State Tracker

This block watches the command pins of a DDR2 memory device on every rising clock edge and keeps the protocol state a controller or a bus monitor needs. It decodes chip select, row strobe, column strobe and write enable into a command. It tracks for each bank whether a row is open and which row that is, and it holds the last value written to each mode register. It also reports whether the device is running normally or has entered one of three low-power modes.

Rows close in three ways: an explicit precharge of one bank, a precharge of every bank, or an auto-precharge. An auto-precharge is requested by a bit of the column address and takes effect a programmable number of cycles after the access. The block raises a one-cycle error for an illegal command sequence, and a separate one-cycle error when clock enable drops during a read or write burst. Typical uses are as a shadow of the device state beside a memory controller, or as a protocol monitor on a captured pin trace.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, and 111 or 110 no-operation. With `cs_n` high, nothing changes and no error is raised, whatever the other command pins carry.
- R2: A command takes effect only at an edge where `cke` is high and `lp_mode` is 0. While in a low-power mode, commands sampled with `cke` low change no state and raise no error.
- R3: An activate to a bank with no open row sets `bank_open[ba]` and stores `addr` as that bank's row in `bank_row[ba*ADDR_W +: ADDR_W]`. Both are visible after the edge that samples the command.
- R4: A precharge with `addr[AP_BIT]` low closes only bank `ba`. A precharge with `addr[AP_BIT]` high closes every bank. Either form cancels any pending auto-precharge on the banks it closes.
- R5: A read or write to an open bank is legal. If `addr[AP_BIT]` is high, that bank closes automatically and `bank_open` falls after edge k+AP_DELAY, where k is the edge of the access. If `addr[AP_BIT]` is low, the bank stays open.
- R6: `err_proto` is high for the one cycle after an edge that samples any of these: a read or write to a bank with no open row (a bank whose auto-precharge completes on that same edge counts as closed); an activate to an open bank; a refresh while any bank is open. A faulted activate, read or write changes no bank state.
- R7: A mode register set with all banks closed stores `addr` in `mode_regs[ba*ADDR_W +: ADDR_W]`. With any bank open, it raises `err_proto` and changes no mode register.
- R8: An edge in normal mode with `cke` low enters a low-power mode and ignores the command. The encoding is 3 for self refresh, 2 for active power-down and 1 for precharge power-down. The mode is 3 if the command is a refresh and all banks are closed; otherwise it is 2 if any bank is open and 1 if none is. A refresh sampled with `cke` low while a bank is open also raises `err_proto`.
- R9: An edge with `cke` high while in a low-power mode returns `lp_mode` to 0. The command sampled on that exit edge is ignored.
- R10: An accepted read or write at edge k opens a burst window covering edges k+1 to k+BURST_CYC. If `cke` is sampled low in normal mode inside that window, `err_cke` is high for one cycle, and the low-power entry still happens.
- R11: After reset, every bank is closed, all rows and mode registers are 0, `lp_mode` is 0 and both error outputs are low. The release of reset is synchronised internally by two flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen at the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Row, column or op-code address bus |
| bank_open | output | 2**BA_W | One bit per bank, set while a row is open |
| bank_row | output | 2**BA_W*ADDR_W | Open row per bank, bank b at bits b*ADDR_W |
| mode_regs | output | 2**BA_W*ADDR_W | Stored mode register values, register b at bits b*ADDR_W |
| lp_mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| err_proto | output | 1 | One-cycle pulse on an illegal command sequence |
| err_cke | output | 1 | One-cycle pulse when clock enable drops inside a burst |

## Verification
The assertions check on every cycle that a deselected or sleeping device changes no mode register and raises no error. They also check that an access to a bank shown closed is flagged, that a precharge-all leaves every bank closed, and that low-power entry from an idle state and exit back to normal follow the clock-enable rules. Several behaviours can only be shown by the bench's scenarios, because they depend on a count or on which row is stored: the exact edge on which an auto-precharge closes a bank, a read that lands on that same edge, the boundaries of the burst window, the choice of active power-down with rows open, and the row and op-code values kept per bank.

// File: rtl/ddr2trk_pkg.sv
package ddr2trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_DESEL,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    LP_NONE     = 2'd0,
    LP_PRE_PD   = 2'd1,
    LP_ACT_PD   = 2'd2,
    LP_SELF_REF = 2'd3
  } lp_e;

endpackage

// File: rtl/ddr2trk_decode.sv
module ddr2trk_decode
  import ddr2trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr2trk_bank.sv
module ddr2trk_bank #(
  parameter int ROW_W    = 14,
  parameter int AP_DELAY = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_set,
  input  logic             pre_clr,
  input  logic             ap_arm,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic             closing_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int CNT_W = $clog2(AP_DELAY + 1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // auto-precharge completes on the edge where the count leaves 1
  assign closing_o = (cnt_q == CNT_W'(1));

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    cnt_d  = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (closing_o) begin
        open_d = 1'b0;
      end
    end
    if (pre_clr) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end
    if (act_set) begin
      open_d = 1'b1;
      row_d  = row_in;
    end
    if (ap_arm) begin
      cnt_d = CNT_W'(AP_DELAY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (act_set) begin
      row_q <= row_d;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

endmodule

// File: rtl/ddr2trk_power.sv
module ddr2trk_power
  import ddr2trk_pkg::*;
#(
  parameter int BURST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic is_ref,
  input  logic any_open,
  input  logic acc_start,
  output lp_e  lp_mode,
  output logic normal,
  output logic err_cke
);

  localparam int BU_W = $clog2(BURST_CYC + 1);

  lp_e             lp_q, lp_d;
  logic [BU_W-1:0] burst_q, burst_d;
  logic            err_q, err_d;

  assign normal = (lp_q == LP_NONE);

  always_comb begin
    lp_d    = lp_q;
    err_d   = 1'b0;
    burst_d = (burst_q != '0) ? burst_q - BU_W'(1) : '0;
    if (acc_start) begin
      burst_d = BU_W'(BURST_CYC);
    end
    if (normal && !cke) begin
      err_d = (burst_q != '0);
      if (is_ref && !any_open) begin
        lp_d = LP_SELF_REF;
      end else if (any_open) begin
        lp_d = LP_ACT_PD;
      end else begin
        lp_d = LP_PRE_PD;
      end
    end else if (!normal && cke) begin
      lp_d = LP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q    <= LP_NONE;
      burst_q <= '0;
      err_q   <= 1'b0;
    end else begin
      lp_q    <= lp_d;
      burst_q <= burst_d;
      err_q   <= err_d;
    end
  end

  assign lp_mode = lp_q;
  assign err_cke = err_q;

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2trk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 14,
  parameter int AP_BIT    = 10,
  parameter int AP_DELAY  = 6,
  parameter int BURST_CYC = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cke,
  input  logic                           cs_n,
  input  logic                           ras_n,
  input  logic                           cas_n,
  input  logic                           we_n,
  input  logic [BA_W-1:0]                ba,
  input  logic [ADDR_W-1:0]              addr,
  output logic [(1<<BA_W)-1:0]           bank_open,
  output logic [(1<<BA_W)*ADDR_W-1:0]    bank_row,
  output logic [(1<<BA_W)*ADDR_W-1:0]    mode_regs,
  output logic [1:0]                     lp_mode,
  output logic                           err_proto,
  output logic                           err_cke
);

  localparam int NB = 1 << BA_W;

  // reset: asserted at once, released after two edges
  logic [1:0] sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_i = sync_q[1];

  cmd_e cmd;

  ddr2trk_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  logic [NB-1:0] open_v, closing_v, eff_open;
  logic          any_eff;
  logic          normal, take, is_rdwr, acc_ok, mrs_ok, err_d, err_q;
  lp_e           lp_s;

  assign eff_open = open_v & ~closing_v;
  assign any_eff  = |eff_open;
  assign take     = cke && normal;
  assign is_rdwr  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign acc_ok   = take && is_rdwr && eff_open[ba];
  assign mrs_ok   = take && (cmd == CMD_MRS) && !any_eff;

  ddr2trk_power #(
    .BURST_CYC (BURST_CYC)
  ) u_pwr (
    .clk       (clk),
    .rst_n     (rst_i),
    .cke       (cke),
    .is_ref    (cmd == CMD_REF),
    .any_open  (any_eff),
    .acc_start (acc_ok),
    .lp_mode   (lp_s),
    .normal    (normal),
    .err_cke   (err_cke)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(g));

    ddr2trk_bank #(
      .ROW_W    (ADDR_W),
      .AP_DELAY (AP_DELAY)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_i),
      .act_set   (take && (cmd == CMD_ACT) && sel && !eff_open[g]),
      .pre_clr   (take && (cmd == CMD_PRE) && (addr[AP_BIT] || sel)),
      .ap_arm    (acc_ok && sel && addr[AP_BIT]),
      .row_in    (addr),
      .open_o    (open_v[g]),
      .closing_o (closing_v[g]),
      .row_o     (bank_row[g*ADDR_W +: ADDR_W])
    );

    logic [ADDR_W-1:0] mr_q;
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        mr_q <= '0;
      end else if (mrs_ok && sel) begin
        mr_q <= addr;
      end
    end
    assign mode_regs[g*ADDR_W +: ADDR_W] = mr_q;
  end

  always_comb begin
    err_d = 1'b0;
    if (take) begin
      unique case (cmd)
        CMD_ACT:        err_d = eff_open[ba];
        CMD_RD, CMD_WR: err_d = !eff_open[ba];
        CMD_MRS:        err_d = any_eff;
        default:        err_d = 1'b0;
      endcase
    end
    if (normal && (cmd == CMD_REF) && any_eff) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign bank_open = open_v;
  assign lp_mode   = lp_s;
  assign err_proto = err_q;

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cke,
  input logic                        cs_n,
  input logic                        ras_n,
  input logic                        cas_n,
  input logic                        we_n,
  input logic [BA_W-1:0]             ba,
  input logic [ADDR_W-1:0]           addr,
  input logic [(1<<BA_W)-1:0]        bank_open,
  input logic [(1<<BA_W)*ADDR_W-1:0] mode_regs,
  input logic [1:0]                  lp_mode,
  input logic                        err_proto,
  input logic                        err_cke
);

  logic pin_ref, pin_rdwr, pin_pre;
  assign pin_ref  = !cs_n && !ras_n && !cas_n && we_n;
  assign pin_rdwr = !cs_n && ras_n && !cas_n;
  assign pin_pre  = !cs_n && !ras_n && cas_n && !we_n;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke && lp_mode == 2'd0) |=> (!err_proto && $stable(mode_regs)));

  // R2
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode != 2'd0 && !cke) |=> (!err_proto && $stable(mode_regs) && $stable(lp_mode)));

  // R6
  closed_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && lp_mode == 2'd0 && pin_rdwr && !bank_open[ba]) |=> err_proto);

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && lp_mode == 2'd0 && pin_pre && addr[AP_BIT]) |=> (bank_open == '0));

  // R8
  idle_pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == 2'd0 && !cke && bank_open == '0 && !pin_ref) |=> (lp_mode == 2'd1));

  // R8
  self_ref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == 2'd0 && !cke && bank_open == '0 && pin_ref) |=> (lp_mode == 2'd3 && !err_proto));

  // R9
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode != 2'd0 && cke) |=> (lp_mode == 2'd0 && $stable(mode_regs) && !err_proto));

  // R10
  no_cke_err_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode != 2'd0) |=> !err_cke);

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
  .BA_W   (BA_W),
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .bank_open (bank_open),
  .mode_regs (mode_regs),
  .lp_mode   (lp_mode),
  .err_proto (err_proto),
  .err_cke   (err_cke)
);

// File: tb/ddr2_cmd_tracker_tb.sv
module ddr2_cmd_tracker_tb;

  localparam int NB  = 4;
  localparam int AW  = 14;
  localparam int APD = 6;
  localparam int BUR = 4;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                         C_NOP = 3'b111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  logic [NB-1:0] bank_open;
  logic [NB*AW-1:0] bank_row, mode_regs;
  logic [1:0] lp_mode;
  logic err_proto, err_cke;

  ddr2_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .bank_open(bank_open), .bank_row(bank_row), .mode_regs(mode_regs),
    .lp_mode(lp_mode), .err_proto(err_proto), .err_cke(err_cke)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";
  bit done = 1'b0;

  // behavioural reference
  bit mopen[NB];
  int mrow[NB], mcnt[NB], mmr[NB];
  int mlp, mburst, rcnt;
  bit merr_p, merr_c;

  task automatic m_reset();
    for (int b = 0; b < NB; b++) begin
      mopen[b] = 0; mrow[b] = 0; mcnt[b] = 0; mmr[b] = 0;
    end
    mlp = 0; mburst = 0; merr_p = 0; merr_c = 0;
  endtask

  task automatic m_step();
    bit eff[NB];
    bit anyeff;
    bit bact;
    int code;
    anyeff = 0;
    for (int b = 0; b < NB; b++) begin
      eff[b] = mopen[b] && (mcnt[b] != 1);
      if (eff[b]) anyeff = 1;
    end
    for (int b = 0; b < NB; b++) begin
      if (mcnt[b] != 0) begin
        if (mcnt[b] == 1) mopen[b] = 0;
        mcnt[b]--;
      end
    end
    bact = (mburst != 0);
    if (mburst > 0) mburst--;
    merr_p = 0;
    merr_c = 0;
    code = {ras_n, cas_n, we_n};
    if (mlp == 0) begin
      if (!cs_n && code == C_REF && anyeff) merr_p = 1;
      if (!cke) begin
        merr_c = bact;
        if (!cs_n && code == C_REF && !anyeff) mlp = 3;
        else mlp = anyeff ? 2 : 1;
      end else if (!cs_n) begin
        case (code)
          C_ACT: if (eff[ba]) merr_p = 1;
                 else begin mopen[ba] = 1; mrow[ba] = addr; end
          C_RD, C_WR: if (!eff[ba]) merr_p = 1;
                 else begin mburst = BUR; if (addr[10]) mcnt[ba] = APD; end
          C_PRE: if (addr[10]) begin
                   for (int b = 0; b < NB; b++) begin mopen[b] = 0; mcnt[b] = 0; end
                 end else begin mopen[ba] = 0; mcnt[ba] = 0; end
          C_MRS: if (anyeff) merr_p = 1; else mmr[ba] = addr;
          default: ;
        endcase
      end
    end else if (cke) begin
      mlp = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0;
      m_reset();
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      m_step();
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (!done) begin
      logic [NB-1:0] eo;
      logic [NB*AW-1:0] er, em;
      for (int b = 0; b < NB; b++) begin
        eo[b] = mopen[b];
        er[b*AW +: AW] = mrow[b][AW-1:0];
        em[b*AW +: AW] = mmr[b][AW-1:0];
      end
      chk("bank_open", 64'(bank_open), 64'(eo));
      chk("bank_row",  64'(bank_row),  64'(er));
      chk("mode_regs", 64'(mode_regs), 64'(em));
      chk("lp_mode",   64'(lp_mode),   64'(mlp));
      chk("err_proto", 64'(err_proto), 64'(merr_p));
      chk("err_cke",   64'(err_cke),   64'(merr_c));
    end
  end

  task automatic issue(input logic k, input logic c, input logic [2:0] rcw,
                       input int b, input int a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw;
    ba = b[1:0]; addr = a[AW-1:0];
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(1, 0, C_NOP, 0, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = C_NOP; ba = 0; addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    nop(4);
    cur_req = "R11";
    chk("reset bank_open", 64'(bank_open), 64'd0);
    chk("reset lp_mode", 64'(lp_mode), 64'd0);

    cur_req = "R1";
    issue(1, 1, C_ACT, 0, 'h111);
    chk("deselect bank_open", 64'(bank_open), 64'd0);
    issue(1, 0, 3'b110, 0, 'h111);
    chk("110 nop bank_open", 64'(bank_open), 64'd0);

    cur_req = "R3";
    issue(1, 0, C_ACT, 0, 'h1234);
    issue(1, 0, C_ACT, 2, 'h0abc);
    chk("open after two activates", 64'(bank_open), 64'b0101);
    chk("bank2 row", 64'(bank_row[2*AW +: AW]), 64'h0abc);

    cur_req = "R6";
    issue(1, 0, C_ACT, 0, 'h0fff);
    chk("activate open bank err", 64'(err_proto), 64'd1);
    chk("row kept", 64'(bank_row[0 +: AW]), 64'h1234);
    issue(1, 0, C_RD, 1, 0);
    chk("read closed bank err", 64'(err_proto), 64'd1);
    issue(1, 0, C_REF, 0, 0);
    chk("refresh with open bank err", 64'(err_proto), 64'd1);

    cur_req = "R4";
    issue(1, 0, C_PRE, 0, 'h0000);
    chk("single precharge", 64'(bank_open), 64'b0100);
    issue(1, 0, C_ACT, 1, 'h22);
    issue(1, 0, C_PRE, 3, 'h0400);
    chk("precharge all", 64'(bank_open), 64'b0000);

    cur_req = "R5";
    issue(1, 0, C_ACT, 3, 'h33);
    issue(1, 0, C_RD, 3, 'h0400);
    nop(APD - 1);
    chk("auto-precharge not yet", 64'(bank_open[3]), 64'd1);
    nop(1);
    chk("auto-precharge closed", 64'(bank_open[3]), 64'd0);
    issue(1, 0, C_ACT, 3, 'h44);
    issue(1, 0, C_WR, 3, 'h0008);
    nop(8);
    chk("plain write keeps open", 64'(bank_open[3]), 64'd1);
    issue(1, 0, C_PRE, 0, 'h0400);

    cur_req = "R6";
    issue(1, 0, C_ACT, 1, 'h55);
    issue(1, 0, C_WR, 1, 'h0400);
    nop(APD - 1);
    issue(1, 0, C_RD, 1, 0);
    chk("read on closing edge err", 64'(err_proto), 64'd1);
    chk("closing bank closed", 64'(bank_open[1]), 64'd0);

    cur_req = "R7";
    issue(1, 0, C_MRS, 2, 'h0442);
    chk("mode reg 2", 64'(mode_regs[2*AW +: AW]), 64'h0442);
    issue(1, 0, C_ACT, 0, 'h7);
    issue(1, 0, C_MRS, 1, 'h0155);
    chk("mrs with open bank err", 64'(err_proto), 64'd1);
    chk("mode reg 1 unchanged", 64'(mode_regs[AW +: AW]), 64'd0);
    issue(1, 0, C_PRE, 0, 'h0400);

    cur_req = "R8";
    issue(0, 0, C_NOP, 0, 0);
    chk("precharge power-down", 64'(lp_mode), 64'd1);
    cur_req = "R2";
    issue(0, 0, C_ACT, 0, 5);
    chk("activate asleep ignored", 64'(bank_open), 64'd0);
    cur_req = "R9";
    issue(1, 0, C_ACT, 0, 5);
    chk("exit to normal", 64'(lp_mode), 64'd0);
    chk("exit edge command ignored", 64'(bank_open), 64'd0);
    cur_req = "R8";
    issue(1, 0, C_ACT, 0, 9);
    issue(0, 0, C_NOP, 0, 0);
    chk("active power-down", 64'(lp_mode), 64'd2);
    issue(1, 0, C_NOP, 0, 0);
    issue(1, 0, C_PRE, 0, 'h0400);
    issue(0, 0, C_REF, 0, 0);
    chk("self refresh", 64'(lp_mode), 64'd3);
    issue(1, 0, C_NOP, 0, 0);
    issue(1, 0, C_ACT, 2, 3);
    issue(0, 0, C_REF, 0, 0);
    chk("refresh entry with open bank", 64'(lp_mode), 64'd2);
    chk("refresh entry err", 64'(err_proto), 64'd1);
    issue(1, 0, C_NOP, 0, 0);
    issue(1, 0, C_PRE, 0, 'h0400);

    cur_req = "R10";
    issue(1, 0, C_ACT, 1, 1);
    issue(1, 0, C_RD, 1, 0);
    issue(0, 0, C_NOP, 0, 0);
    chk("cke drop in burst", 64'(err_cke), 64'd1);
    issue(1, 0, C_NOP, 0, 0);
    issue(1, 0, C_RD, 1, 0);
    nop(BUR);
    issue(0, 0, C_NOP, 0, 0);
    chk("cke drop after burst", 64'(err_cke), 64'd0);
    issue(1, 0, C_NOP, 0, 0);
    issue(1, 0, C_PRE, 0, 'h0400);
    nop(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule